// File: doc/BRIEF.md
# Nibble-Wide Link Port

This block is one end of a point-to-point link between two processors. The link carries four data bits, a strobe clock and an acknowledge line. Each level change of the strobe clock carries one nibble, so both edges carry data and a full strobe period moves a byte. A configuration input makes the port either a sender or a receiver. A second input selects the word size, which is 32 or 48 bits.

As a sender, the port takes words from a local write strobe into a two-entry buffer. It cuts each word into nibbles, least significant nibble first, and sends them. It starts a new word only while the far end raises acknowledge. As a receiver, it collects nibbles into words in a two-entry buffer that local logic reads. It raises acknowledge only while a buffer slot is still free and not already claimed by a word that is partly received. In both roles a status output reports how many buffers are full. In this implementation the strobe clock changes at most once per system clock, and the receiver samples the incoming strobe synchronously.

Top module: `lnk_port`

## Requirements
- R1: After reset, buf_cnt is 0, ovf_err is 0, link_clk_o is 0 and link_dat_o is 0.
- R2: In sender mode, link_clk_o changes level once for every nibble put on link_dat_o. Bits 3:0 of a word go first, then each higher nibble in turn. A 32-bit word (cfg_wide=0, bits 31:0 of the written data) takes 8 nibbles. A 48-bit word (cfg_wide=1) takes 12.
- R3: In receiver mode, every level change of link_clk_i captures link_dat_i. The first captured nibble of a word becomes bits 3:0. After 8 or 12 nibbles the word enters the receive buffer. In 32-bit mode bits 47:32 of rd_data read as zero.
- R4: The sender begins a word only in a cycle where link_ack_i is 1. Once started, the word completes whatever link_ack_i does. Without acknowledge, link_clk_o holds its level.
- R5: In receiver mode, link_ack_o is 1 exactly when the number of full receive buffers, plus one if a word is partly received, is less than 2.
- R6: buf_cnt reports how many of the two buffers of the active direction are full (0, 1 or 2). Words leave each buffer in the order they entered.
- R7: A write presented while buf_cnt reads 2 is dropped, even if a buffer empties on that same clock edge. Such a write sets ovf_err, and ovf_err stays set until reset.
- R8: With cfg_tx=1 the port is a sender, and link_ack_o stays 0. With cfg_tx=0 it is a receiver: wr_en has no effect on buf_cnt, and link_clk_o does not move.
- R9: When the next word is already buffered and link_ack_i is 1, its first nibble follows the last nibble of the previous word on the very next cycle, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx | input | 1 | 1 selects sender, 0 selects receiver |
| cfg_wide | input | 1 | 1 selects 48-bit words, 0 selects 32-bit words |
| wr_en | input | 1 | Write strobe into the send buffer |
| wr_data | input | 48 | Word to send |
| rd_en | input | 1 | Read strobe that removes the oldest received word |
| rd_data | output | 48 | Oldest received word |
| buf_cnt | output | 2 | Number of full buffers in the active direction |
| ovf_err | output | 1 | Sticky flag for a write dropped at full |
| link_clk_o | output | 1 | Outgoing strobe clock |
| link_dat_o | output | 4 | Outgoing nibble |
| link_ack_i | input | 1 | Acknowledge from the far receiver |
| link_clk_i | input | 1 | Incoming strobe clock |
| link_dat_i | input | 4 | Incoming nibble |
| link_ack_o | output | 1 | Acknowledge to the far sender |

## Verification
Two pairs of events can fall on the same clock edge. On the send side, a local write can meet a full buffer on the edge where the serializer takes the head word for a back-to-back transfer. The bench provokes this with random writes under a random acknowledge pattern. It predicts that the write is dropped whenever buf_cnt read 2 before that edge, and it then checks both ovf_err and the stream of words sent. On the receive side, the last nibble of a word can complete on the edge where a local read removes the oldest word. The bench issues reads on the same cycle as final nibbles and checks buf_cnt, link_ack_o and rd_data against its own count of stored and partly received words.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  localparam int unsigned NIB_W = 4;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} lnk_dir_e;
endpackage

// File: rtl/lnk_fifo2.sv
module lnk_fifo2 #(
  parameter int unsigned W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic [1:0]   cnt
);
  localparam int unsigned DEPTH = 2;

  logic [W-1:0] mem_q [DEPTH];
  logic         wp_q, rp_q;
  logic [1:0]   cnt_q;
  logic         push_ok, pop_ok;

  // a push at full is refused even when a pop happens on the same edge
  assign push_ok = push && (cnt_q != 2'(DEPTH));
  assign pop_ok  = pop && (cnt_q != 2'd0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem_q[i] <= '0;
      else if (push_ok && (wp_q == 1'(i))) mem_q[i] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= 1'b0;
      rp_q  <= 1'b0;
      cnt_q <= 2'd0;
    end else begin
      if (push_ok) wp_q <= ~wp_q;
      if (pop_ok)  rp_q <= ~rp_q;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 2'd1;
        2'b01:   cnt_q <= cnt_q - 2'd1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout = mem_q[rp_q];
  assign cnt  = cnt_q;
endmodule

// File: rtl/lnk_ser.sv
module lnk_ser
  import lnk_pkg::*;
#(
  parameter int unsigned WORD_W   = 48,
  parameter int unsigned NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wide,
  input  logic              avail,
  input  logic [WORD_W-1:0] head,
  input  logic              ack_i,
  output logic              take,
  output logic              clk_o,
  output logic [NIB_W-1:0]  dat_o
);
  localparam int unsigned NMAX = WORD_W / NIB_W;
  localparam int unsigned NNAR = NARROW_W / NIB_W;
  localparam int unsigned CW   = $clog2(NMAX + 1);

  function automatic logic [CW-1:0] nib_len(input logic w);
    return w ? CW'(NMAX) : CW'(NNAR);
  endfunction

  logic [CW-1:0]     rem_q;
  logic [WORD_W-1:0] sh_q;

  // a new word is only taken between words, and only under acknowledge
  assign take = en && (rem_q == '0) && avail && ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      sh_q  <= '0;
      clk_o <= 1'b0;
      dat_o <= '0;
    end else if (!en) begin
      rem_q <= '0;
    end else if (take) begin
      dat_o <= head[NIB_W-1:0];
      sh_q  <= head >> NIB_W;
      clk_o <= ~clk_o;
      rem_q <= nib_len(wide) - CW'(1);
    end else if (rem_q != '0) begin
      dat_o <= sh_q[NIB_W-1:0];
      sh_q  <= sh_q >> NIB_W;
      clk_o <= ~clk_o;
      rem_q <= rem_q - CW'(1);
    end
  end

  AST_START_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_o != $past(clk_o)) && ($past(rem_q) == '0)) |-> $past(ack_i)); // R4
  AST_IDLE_CLK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rem_q) == '0) && !$past(ack_i)) |-> $stable(clk_o)); // R4
endmodule

// File: rtl/lnk_des.sv
module lnk_des
  import lnk_pkg::*;
#(
  parameter int unsigned WORD_W   = 48,
  parameter int unsigned NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wide,
  input  logic              clk_i,
  input  logic [NIB_W-1:0]  dat_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld,
  output logic              part
);
  localparam int unsigned NMAX = WORD_W / NIB_W;
  localparam int unsigned NNAR = NARROW_W / NIB_W;
  localparam int unsigned CW   = $clog2(NMAX + 1);

  function automatic logic [CW-1:0] nib_len(input logic w);
    return w ? CW'(NMAX) : CW'(NNAR);
  endfunction

  function automatic logic [WORD_W-1:0] put_nib(input logic [WORD_W-1:0] w,
                                                input logic [CW-1:0] idx,
                                                input logic [NIB_W-1:0] n);
    logic [WORD_W-1:0] ext;
    ext = '0;
    ext[NIB_W-1:0] = n;
    return w | (ext << (NIB_W * idx));
  endfunction

  logic              prev_q;
  logic [WORD_W-1:0] acc_q;
  logic [CW-1:0]     cnt_q;
  logic              edge_evt, last_nib;

  assign edge_evt = en && (clk_i != prev_q);
  assign last_nib = (cnt_q == nib_len(wide) - CW'(1));
  assign word_o   = put_nib(acc_q, cnt_q, dat_i);
  assign word_vld = edge_evt && last_nib;
  assign part     = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= clk_i;
      if (!en) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else if (edge_evt) begin
        if (last_nib) begin
          acc_q <= '0;
          cnt_q <= '0;
        end else begin
          acc_q <= word_o;
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lnk_port.sv
module lnk_port
  import lnk_pkg::*;
#(
  parameter int unsigned WORD_W   = 48,
  parameter int unsigned NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tx,
  input  logic              cfg_wide,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic [1:0]        buf_cnt,
  output logic              ovf_err,
  output logic              link_clk_o,
  output logic [NIB_W-1:0]  link_dat_o,
  input  logic              link_ack_i,
  input  logic              link_clk_i,
  input  logic [NIB_W-1:0]  link_dat_i,
  output logic              link_ack_o
);
  logic              is_tx;
  logic [WORD_W-1:0] tx_head, rx_word;
  logic [1:0]        tx_cnt, rx_cnt;
  logic              tx_take, rx_push, rx_part, tx_wr_full;

  assign is_tx      = (lnk_dir_e'(cfg_tx) == DIR_TX);
  assign tx_wr_full = is_tx && wr_en && (tx_cnt == 2'd2);

  lnk_fifo2 #(.W(WORD_W)) u_txbuf (
    .clk(clk), .rst_n(rst_n), .push(is_tx && wr_en), .din(wr_data),
    .pop(tx_take), .dout(tx_head), .cnt(tx_cnt));

  lnk_ser #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .en(is_tx), .wide(cfg_wide),
    .avail(tx_cnt != 2'd0), .head(tx_head), .ack_i(link_ack_i),
    .take(tx_take), .clk_o(link_clk_o), .dat_o(link_dat_o));

  lnk_des #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_des (
    .clk(clk), .rst_n(rst_n), .en(!is_tx), .wide(cfg_wide),
    .clk_i(link_clk_i), .dat_i(link_dat_i), .word_o(rx_word),
    .word_vld(rx_push), .part(rx_part));

  lnk_fifo2 #(.W(WORD_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
    .pop(!is_tx && rd_en), .dout(rd_data), .cnt(rx_cnt));

  // a partly received word has already claimed a slot
  assign link_ack_o = !is_tx && ((rx_cnt == 2'd0) || ((rx_cnt == 2'd1) && !rx_part));
  assign buf_cnt    = is_tx ? tx_cnt : rx_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf_err <= 1'b0;
    else if (tx_wr_full) ovf_err <= 1'b1;
  end

  AST_FULL_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_full && !tx_take) |=> (tx_cnt == 2'd2)); // R7
  AST_FULL_WR_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_full && tx_take) |=> (tx_cnt == 2'd1)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf_err) |-> ovf_err); // R7
  AST_RX_NO_PUSH_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (rx_cnt != 2'd2)); // R5
  AST_RX_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(is_tx) |-> $stable(link_clk_o)); // R8
endmodule

// File: tb/lnk_port_tb.sv
module lnk_port_tb;
  logic        clk = 1'b0;
  logic        rst_n, cfg_tx, cfg_wide, wr_en, rd_en;
  logic [47:0] wr_data, rd_data;
  logic [1:0]  buf_cnt;
  logic        ovf_err, link_clk_o, link_ack_i, link_clk_i, link_ack_o;
  logic [3:0]  link_dat_o, link_dat_i;

  always #5 clk = ~clk;

  lnk_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_tx(cfg_tx), .cfg_wide(cfg_wide),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .buf_cnt(buf_cnt), .ovf_err(ovf_err), .link_clk_o(link_clk_o),
    .link_dat_o(link_dat_o), .link_ack_i(link_ack_i), .link_clk_i(link_clk_i),
    .link_dat_i(link_dat_i), .link_ack_o(link_ack_o));

  int nchk = 0, nfail = 0, cyc = 0;
  logic [47:0] txq[$];
  logic [47:0] rxq[$];
  bit   exp_err;
  int   mcnt, part;
  logic mon_last = 1'b0;
  int   mon_idx = 0, tog_cnt = 0;
  logic [47:0] mon_acc = '0;

  function automatic int nlen(bit w);
    return w ? 12 : 8;
  endfunction
  function automatic logic [47:0] mask(logic [47:0] d, bit w);
    return w ? d : {16'h0, d[31:0]};
  endfunction
  function automatic logic [3:0] nib_of(logic [47:0] d, int i);
    return d[i*4 +: 4];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // far-end receiver model for sender mode
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      mon_last = 1'b0; mon_idx = 0; mon_acc = '0;
    end else if (link_clk_o !== mon_last) begin
      mon_last = link_clk_o;
      tog_cnt++;
      if (!cfg_tx) chk(0, "R8 link clock moved in receive mode", 48'(link_clk_o), 48'(mon_last));
      if (mon_idx == 0) chk(link_ack_i === 1'b1, "R4 word started without acknowledge", 48'(link_ack_i), 48'd1);
      mon_acc[mon_idx*4 +: 4] = link_dat_o;
      mon_idx++;
      if (mon_idx == nlen(cfg_wide)) begin
        if (txq.size() == 0) chk(0, "R2 word sent that was never accepted", mon_acc, 48'd0);
        else begin
          chk(mon_acc === txq[0], "R2 R6 serialized word", mon_acc, txq[0]);
          void'(txq.pop_front());
        end
        mon_idx = 0; mon_acc = '0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic do_reset(input bit tx, input bit wide);
    @(negedge clk);
    rst_n = 1'b0; cfg_tx = tx; cfg_wide = wide;
    wr_en = 0; wr_data = '0; rd_en = 0; link_ack_i = 0; link_clk_i = 0; link_dat_i = '0;
    exp_err = 0; txq.delete(); rxq.delete(); mcnt = 0; part = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic tx_cycle(input bit wr, input logic [47:0] d, input bit ack);
    @(negedge clk);
    chk(ovf_err === exp_err, "R7 overflow flag", 48'(ovf_err), 48'(exp_err));
    chk(link_ack_o === 1'b0, "R8 acknowledge low in send mode", 48'(link_ack_o), 48'd0);
    if (wr) begin
      if (buf_cnt == 2'd2) exp_err = 1;
      else txq.push_back(mask(d, cfg_wide));
    end
    wr_en = wr; wr_data = d; link_ack_i = ack;
  endtask

  task automatic rx_cycle(input bit tog, input logic [3:0] nib, input bit rd);
    @(negedge clk);
    chk(buf_cnt == 2'(mcnt), "R6 receive buffer count", 48'(buf_cnt), 48'(mcnt));
    chk(link_ack_o === ((mcnt + int'(part != 0)) < 2), "R5 acknowledge",
        48'(link_ack_o), 48'((mcnt + int'(part != 0)) < 2));
    if (rd && mcnt > 0) begin
      chk(rd_data === rxq[0], "R3 received word", rd_data, rxq[0]);
      void'(rxq.pop_front());
      mcnt--;
      rd_en = 1;
    end else rd_en = 0;
    if (tog) begin
      link_dat_i = nib;
      link_clk_i = ~link_clk_i;
    end
  endtask

  task automatic send_part(input logic [47:0] w, input int first, input int last_excl, input bit rnd);
    for (int i = first; i < last_excl; i++) begin
      if (i == 0) while (mcnt >= 2) rx_cycle(0, '0, 1);
      if (rnd) while ($urandom % 3 == 0) rx_cycle(0, '0, 1'($urandom % 2));
      rx_cycle(1, nib_of(w, i), rnd ? 1'($urandom % 2) : 1'b0);
      part++;
      if (part == nlen(cfg_wide)) begin
        rxq.push_back(mask(w, cfg_wide));
        mcnt++;
        part = 0;
      end
    end
  endtask

  initial begin
    int t0;
    void'($urandom(32'd7));
    rst_n = 0; cfg_tx = 1; cfg_wide = 0; wr_en = 0; wr_data = '0; rd_en = 0;
    link_ack_i = 0; link_clk_i = 0; link_dat_i = '0;

    // sender, 32-bit words
    do_reset(1, 0);
    @(negedge clk);
    chk(buf_cnt == 2'd0, "R1 buffer count after reset", 48'(buf_cnt), 48'd0);
    chk(ovf_err === 1'b0, "R1 error flag after reset", 48'(ovf_err), 48'd0);
    chk(link_clk_o === 1'b0, "R1 link clock after reset", 48'(link_clk_o), 48'd0);
    chk(link_dat_o === 4'd0, "R1 link data after reset", 48'(link_dat_o), 48'd0);
    tx_cycle(1, 48'hFEDC_89AB_4C2D, 1);
    repeat (12) tx_cycle(0, '0, 1);
    chk(txq.size() == 0, "R2 narrow word delivered", 48'(txq.size()), 48'd0);

    tx_cycle(1, 48'h0000_1111_2222, 0);
    tx_cycle(1, 48'h0000_3333_4444, 0);
    tx_cycle(1, 48'h0000_5555_6666, 0);
    t0 = tog_cnt;
    repeat (20) tx_cycle(0, '0, 0);
    chk(tog_cnt == t0, "R4 clock held without acknowledge", 48'(tog_cnt - t0), 48'd0);
    chk(buf_cnt == 2'd2, "R6 both send buffers full", 48'(buf_cnt), 48'd2);
    chk(ovf_err === 1'b1, "R7 error after write at full", 48'(ovf_err), 48'd1);
    t0 = tog_cnt;
    tx_cycle(0, '0, 1);
    repeat (16) tx_cycle(0, '0, 1);
    chk(tog_cnt - t0 == 16, "R9 back-to-back nibbles", 48'(tog_cnt - t0), 48'd16);
    tx_cycle(0, '0, 1);
    chk(tog_cnt - t0 == 16, "R9 stream stops after two words", 48'(tog_cnt - t0), 48'd16);
    chk(txq.size() == 0, "R7 dropped word never sent", 48'(txq.size()), 48'd0);

    // sender, 48-bit words, random traffic
    do_reset(1, 1);
    tx_cycle(1, 48'h9A8B_7C6D_5E4F, 1);
    repeat (14) tx_cycle(0, '0, 1);
    chk(txq.size() == 0, "R2 wide word delivered", 48'(txq.size()), 48'd0);
    for (int k = 0; k < 400; k++)
      tx_cycle(1'($urandom % 5 < 2), {$urandom, $urandom}, 1'($urandom % 10 < 7));
    repeat (40) tx_cycle(0, '0, 1);
    chk(txq.size() == 0, "R2 all accepted words delivered", 48'(txq.size()), 48'd0);
    chk(buf_cnt == 2'd0, "R6 send buffers drained", 48'(buf_cnt), 48'd0);

    // receiver, 32-bit words
    do_reset(0, 0);
    wr_en = 1; wr_data = 48'h1234_5678_9ABC;
    repeat (3) rx_cycle(0, '0, 0);
    wr_en = 0;
    chk(buf_cnt == 2'd0, "R8 write ignored in receive mode", 48'(buf_cnt), 48'd0);
    send_part(48'hFFFF_CAFE_F00D, 0, 8, 0);
    send_part(48'h0000_0BAD_BEEF, 0, 4, 0);
    rx_cycle(0, '0, 0);
    chk(link_ack_o === 1'b0, "R5 partial word claims last slot", 48'(link_ack_o), 48'd0);
    send_part(48'h0000_0BAD_BEEF, 4, 8, 0);
    rx_cycle(0, '0, 0);
    chk(buf_cnt == 2'd2, "R6 both receive buffers full", 48'(buf_cnt), 48'd2);
    rx_cycle(0, '0, 1);
    rx_cycle(0, '0, 1);
    rx_cycle(0, '0, 0);
    chk(buf_cnt == 2'd0, "R3 R6 both words read", 48'(buf_cnt), 48'd0);
    for (int k = 0; k < 15; k++) send_part({$urandom, $urandom}, 0, 8, 1);
    while (mcnt > 0) rx_cycle(0, '0, 1);
    rx_cycle(0, '0, 0);

    // receiver, 48-bit words, random gaps and reads
    do_reset(0, 1);
    for (int k = 0; k < 25; k++) send_part({$urandom, $urandom}, 0, 12, 1);
    while (mcnt > 0) rx_cycle(0, '0, 1);
    rx_cycle(0, '0, 0);
    chk(buf_cnt == 2'd0, "R3 all received words read", 48'(buf_cnt), 48'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule